// File: doc/BRIEF.md
# Sprite Line Buffer with First-Writer Priority

This block turns the sprites chosen for the next scan line into a row of pixels. During horizontal flyback it walks a fixed number of sprite slots, one sprite column per clock, at twice the pixel rate. For each slot it reads a sprite entry (valid flag, horizontal position, colour set, mirror flag) and a 3-bit pixel from a graphics port. Each non-transparent pixel becomes an 8-bit word made of the colour set above the pixel value, and it goes into a line RAM at the column the sprite covers.

A location is written only while it still holds zero, so the sprite handled first stays in front. During the visible part of the line the RAM is read one location per pixel strobe and handed to the video mixer. The location is zeroed in the same cycle it is read, so the RAM is empty when the next flyback starts. A screen-mirror input reverses the whole line inside the block, and no outside logic is needed for it.

Top module: `sprite_line_buf`

## Requirements
- R1: While `hcnt[8]` is 0 the block runs 256 fill slots, one per clock, starting with slot 0 on the first flyback clock. Slot k presents `spr_sel = k/32` and `gfx_col = k%32`. The slot counter returns to 0 whenever `hcnt[8]` is 1.
- R2: A written pixel word is `{spr_color[4:0], gfx_pix[2:0]}`. It goes to column `spr_x + gfx_col` when `spr_mirror` is 0, and to `spr_x + 31 - gfx_col` when `spr_mirror` is 1.
- R3: A location that already holds a non-zero word is never overwritten during the fill, so the sprite written first wins.
- R4: While `hcnt[8]` is 1 and `pix_en` is 1, the word for column `hcnt[7:0]` appears on `pix_out` after the clock edge and that location is zeroed. A line that is read out fully leaves the buffer empty for the next fill.
- R5: A pixel value of 0 is never written and does not block sprites handled later.
- R6: A slot whose entry has `spr_valid` equal to 0 writes nothing.
- R7: Columns wrap modulo 256, so a sprite that passes column 255 continues at column 0.
- R8: With `flip_scr` equal to 1 during both fill and readout, the word that would appear at column h appears at column 255-h.
- R9: `pix_out` is 0 on the clock after any flyback cycle. During the visible part, a cycle with `pix_en` equal to 0 leaves `pix_out` unchanged.
- R10: After reset `pix_out` is 0 and every buffer location reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| hcnt | input | 9 | Horizontal counter; bit 8 high marks the visible part |
| pix_en | input | 1 | Pixel strobe during the visible part |
| flip_scr | input | 1 | Mirror the whole line |
| spr_sel | output | 3 | Sprite entry index of the current fill slot |
| gfx_col | output | 5 | Sprite column of the current fill slot |
| spr_valid | input | 1 | Selected entry holds a sprite |
| spr_x | input | 8 | Leftmost column of the selected sprite |
| spr_color | input | 5 | Colour set of the selected sprite |
| spr_mirror | input | 1 | Reverse the sprite's column order |
| gfx_pix | input | 3 | Pixel at the selected entry and column, 0 meaning transparent |
| pix_out | output | 8 | Buffer word for the mixer |

## Verification
Two functions share one cycle. The first is the read of a location and its zeroing, which both happen on every visible strobe. The second is a new fill write and the zero test on the word already stored at that column, because overlapping sprites contend for one location. The first pair is provoked by filling a line and then filling the next line with no valid sprites; a correct design shows all zeros on that second line. The second pair is provoked with overlapping sprites, both solid and with transparent holes, and a scoreboard built from the priority rule judges the result column by column.

// File: rtl/slb_pkg.sv
package slb_pkg;
   typedef enum logic {PH_FILL = 1'b0, PH_SHOW = 1'b1} phase_e;

   function automatic int unsigned slb_log2(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction
endpackage

// File: rtl/slb_fill_seq.sv
module slb_fill_seq #(
   parameter int unsigned NUM_SPR = 8,
   parameter int unsigned SPR_W   = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fill_win,
   output logic active,
   output logic [slb_pkg::slb_log2(NUM_SPR)-1:0] ent_idx,
   output logic [slb_pkg::slb_log2(SPR_W)-1:0]   col_idx
);
   localparam int unsigned ENT_W  = slb_pkg::slb_log2(NUM_SPR);
   localparam int unsigned COL_W  = slb_pkg::slb_log2(SPR_W);
   localparam int unsigned SLOT_W = ENT_W + COL_W;
   localparam int unsigned SLOTS  = NUM_SPR * SPR_W;

   logic [SLOT_W:0] slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (!fill_win) begin
         slot_q <= '0;
      end else if (!slot_q[SLOT_W]) begin
         slot_q <= slot_q + 1'b1;
      end
   end

   assign active  = fill_win && !slot_q[SLOT_W];
   assign col_idx = slot_q[COL_W-1:0];
   assign ent_idx = slot_q[SLOT_W-1:COL_W];

   // R1: slot counter never passes the slot budget
   p_slot_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      slot_q <= (SLOT_W+1)'(SLOTS));
   // R1: counter restarts outside the fill window
   p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_win |=> slot_q == '0);
endmodule

// File: rtl/slb_addr_gen.sv
module slb_addr_gen #(
   parameter int unsigned LINE_W       = 256,
   parameter int unsigned SPR_W        = 32,
   parameter bit          FLIP_AT_READ = 1'b0
) (
   input  logic [slb_pkg::slb_log2(LINE_W)-1:0] spr_x,
   input  logic [slb_pkg::slb_log2(SPR_W)-1:0]  col,
   input  logic                                 mirror,
   input  logic                                 flip,
   input  logic [slb_pkg::slb_log2(LINE_W)-1:0] hpos,
   output logic [slb_pkg::slb_log2(LINE_W)-1:0] wr_addr,
   output logic [slb_pkg::slb_log2(LINE_W)-1:0] rd_addr
);
   localparam int unsigned POS_W = slb_pkg::slb_log2(LINE_W);
   localparam int unsigned COL_W = slb_pkg::slb_log2(SPR_W);

   logic [COL_W-1:0] col_eff;
   logic [POS_W-1:0] base;

   always_comb begin
      col_eff = mirror ? ~col : col;
      base    = spr_x + POS_W'(col_eff);
   end

   generate
      if (FLIP_AT_READ) begin : g_flip_rd
         assign wr_addr = base;
         assign rd_addr = flip ? ~hpos : hpos;
      end else begin : g_flip_wr
         assign wr_addr = flip ? ~base : base;
         assign rd_addr = hpos;
      end
   endgenerate
endmodule

// File: rtl/slb_line_ram.sv
module slb_line_ram #(
   parameter int unsigned DEPTH  = 256,
   parameter int unsigned WORD_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_en,
   input  logic [slb_pkg::slb_log2(DEPTH)-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data,
   input  logic wr_req,
   input  logic [slb_pkg::slb_log2(DEPTH)-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data
);
   localparam int unsigned AW = slb_pkg::slb_log2(DEPTH);

   logic [WORD_W-1:0] mem [DEPTH];
   logic              slot_free;

   assign rd_data   = mem[rd_addr];
   assign slot_free = (mem[wr_addr] == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (rd_en) mem[rd_addr] <= '0;
         else if (wr_req && slot_free) mem[wr_addr] <= wr_data;
      end
   end

   // R1: fill and readout never share a cycle
   p_rd_wr_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && wr_req));
   // R4: a location read out holds zero afterwards
   p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> mem[$past(rd_addr)] == '0);
   // R3: an occupied location survives a later write request
   p_write_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !rd_en && mem[wr_addr] != '0) |=>
         mem[$past(wr_addr)] == $past(mem[wr_addr]));

   if (AW < 1) begin : g_bad_depth
      $error("slb_line_ram: DEPTH must be at least 2");
   end
endmodule

// File: rtl/sprite_line_buf.sv
module sprite_line_buf #(
   parameter int unsigned LINE_W       = 256,
   parameter int unsigned NUM_SPR      = 8,
   parameter int unsigned SPR_W        = 32,
   parameter int unsigned PIX_W        = 3,
   parameter int unsigned COLOR_W      = 5,
   parameter bit          FLIP_AT_READ = 1'b0
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic [slb_pkg::slb_log2(LINE_W):0]      hcnt,
   input  logic                                    pix_en,
   input  logic                                    flip_scr,
   output logic [slb_pkg::slb_log2(NUM_SPR)-1:0]   spr_sel,
   output logic [slb_pkg::slb_log2(SPR_W)-1:0]     gfx_col,
   input  logic                                    spr_valid,
   input  logic [slb_pkg::slb_log2(LINE_W)-1:0]    spr_x,
   input  logic [COLOR_W-1:0]                      spr_color,
   input  logic                                    spr_mirror,
   input  logic [PIX_W-1:0]                        gfx_pix,
   output logic [PIX_W+COLOR_W-1:0]                pix_out
);
   import slb_pkg::*;

   localparam int unsigned POS_W  = slb_log2(LINE_W);
   localparam int unsigned WORD_W = PIX_W + COLOR_W;

   if ((1 << POS_W) != LINE_W) begin : g_bad_line
      $error("sprite_line_buf: LINE_W must be a power of two");
   end
   if (NUM_SPR * SPR_W != LINE_W) begin : g_bad_budget
      $error("sprite_line_buf: fill slots must equal the flyback length at double rate");
   end
   if ((1 << slb_log2(SPR_W)) != SPR_W || (1 << slb_log2(NUM_SPR)) != NUM_SPR) begin : g_bad_pow
      $error("sprite_line_buf: NUM_SPR and SPR_W must be powers of two");
   end

   phase_e            phase;
   logic              fill_on;
   logic [POS_W-1:0]  wr_addr, rd_addr;
   logic [WORD_W-1:0] rd_word;
   logic              wr_req, rd_en;

   assign phase = phase_e'(hcnt[POS_W]);

   slb_fill_seq #(.NUM_SPR(NUM_SPR), .SPR_W(SPR_W)) i_seq (
      .clk(clk), .rst_n(rst_n),
      .fill_win(phase == PH_FILL),
      .active(fill_on), .ent_idx(spr_sel), .col_idx(gfx_col)
   );

   slb_addr_gen #(.LINE_W(LINE_W), .SPR_W(SPR_W), .FLIP_AT_READ(FLIP_AT_READ)) i_addr (
      .spr_x(spr_x), .col(gfx_col), .mirror(spr_mirror), .flip(flip_scr),
      .hpos(hcnt[POS_W-1:0]), .wr_addr(wr_addr), .rd_addr(rd_addr)
   );

   assign wr_req = fill_on && spr_valid && (gfx_pix != '0);
   assign rd_en  = (phase == PH_SHOW) && pix_en;

   slb_line_ram #(.DEPTH(LINE_W), .WORD_W(WORD_W)) i_ram (
      .clk(clk), .rst_n(rst_n),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_word),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data({spr_color, gfx_pix})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pix_out <= '0;
      else if (phase != PH_SHOW) pix_out <= '0;
      else if (pix_en)         pix_out <= rd_word;
   end

   // R9: idle visible cycles hold the output
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hcnt[POS_W] && !pix_en) |=> $stable(pix_out));
   // R5: transparent pixels never reach the RAM write port
   p_transparent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (gfx_pix == '0) |-> !wr_req);
   // R6: invalid entries never reach the RAM write port
   p_skip_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !spr_valid |-> !wr_req);
endmodule

// File: tb/test_sprite_line_buf.sv
module test_sprite_line_buf;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] hcnt = 9'h100;
   logic       pix_en = 1'b0;
   logic       flip_scr = 1'b0;
   logic [2:0] spr_sel;
   logic [4:0] gfx_col;
   logic [7:0] pix_out;

   logic       t_valid [8];
   logic [7:0] t_x     [8];
   logic [4:0] t_color [8];
   logic       t_mir   [8];
   logic [2:0] t_pix   [8][32];

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sprite_line_buf i_sprite_line_buf (
      .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .pix_en(pix_en), .flip_scr(flip_scr),
      .spr_sel(spr_sel), .gfx_col(gfx_col),
      .spr_valid(t_valid[spr_sel]), .spr_x(t_x[spr_sel]), .spr_color(t_color[spr_sel]),
      .spr_mirror(t_mir[spr_sel]), .gfx_pix(t_pix[spr_sel][gfx_col]),
      .pix_out(pix_out)
   );

   // scoreboard queues
   logic [7:0] q_val [$];
   string      q_tag [$];
   int         q_col [$];
   logic       rd_seen = 1'b0;

   always @(posedge clk) rd_seen <= rst_n && hcnt[8] && pix_en;

   always @(negedge clk) begin
      if (rd_seen) begin
         checks++;
         if (q_val.size() == 0) begin
            errors++;
            $display("FAIL %s: unexpected pixel, got %h expected none", "R4", pix_out);
         end else begin
            logic [7:0] e;
            string tg;
            int c;
            e = q_val.pop_front(); tg = q_tag.pop_front(); c = q_col.pop_front();
            if (pix_out !== e) begin
               errors++;
               $display("FAIL %s: column %0d got %h expected %h", tg, c, pix_out, e);
            end
         end
      end
   end

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, expv);
      end
   endtask

   task automatic clear_table();
      for (int e = 0; e < 8; e++) begin
         t_valid[e] = 1'b0; t_x[e] = 8'd0; t_color[e] = 5'd0; t_mir[e] = 1'b0;
         for (int c = 0; c < 32; c++) t_pix[e][c] = 3'd0;
      end
   endtask

   // mode 0 solid, 1 holes on even columns
   task automatic set_spr(input int e, input logic [7:0] x, input logic [4:0] colr,
                          input logic mir, input int mode);
      t_valid[e] = 1'b1; t_x[e] = x; t_color[e] = colr; t_mir[e] = mir;
      for (int c = 0; c < 32; c++) begin
         if (mode == 1 && (c % 2) == 0) t_pix[e][c] = 3'd0;
         else t_pix[e][c] = 3'((e + c) % 7 + 1);
      end
   endtask

   task automatic run_line(input string tag, input bit seq_chk);
      logic [7:0] expb [256];
      for (int a = 0; a < 256; a++) expb[a] = 8'd0;
      for (int e = 0; e < 8; e++)
         for (int c = 0; c < 32; c++)
            if (t_valid[e] && t_pix[e][c] != 3'd0) begin
               logic [7:0] a;
               a = t_x[e] + 8'(t_mir[e] ? 31 - c : c);
               if (flip_scr) a = 8'd255 - a;
               if (expb[a] == 8'd0) expb[a] = {t_color[e], t_pix[e][c]};
            end
      // flyback
      @(negedge clk);
      hcnt = 9'h000; pix_en = 1'b0;
      for (int k = 0; k < 260; k++) begin
         @(negedge clk);
         #1;
         if (k == 0) check("R9", pix_out, 8'h00);
         if (seq_chk && k < 255 && (k % 37 == 0 || k == 254)) begin
            check("R1", {5'd0, spr_sel}, 8'((k + 1) / 32));
            check("R1", {3'd0, gfx_col}, 8'((k + 1) % 32));
         end
      end
      // visible
      for (int h = 0; h < 256; h++) begin
         @(negedge clk);
         if (h == 100) begin
            pix_en = 1'b0;
            @(negedge clk);
            check("R9", pix_out, expb[99]);
         end
         hcnt = {1'b1, 8'(h)}; pix_en = 1'b1;
         q_val.push_back(expb[h]); q_tag.push_back(tag); q_col.push_back(h);
      end
      @(negedge clk);
      pix_en = 1'b0;
   endtask

   initial begin
      clear_table();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10", pix_out, 8'h00);
      // R10: buffer empty after reset
      run_line("R10", 1'b0);
      // R1 and R2: single sprite, then mirrored sprite
      set_spr(0, 8'd20, 5'd9, 1'b0, 0);
      run_line("R2", 1'b1);
      clear_table();
      set_spr(3, 8'd100, 5'd17, 1'b1, 0);
      run_line("R2", 1'b0);
      // R3: overlapping solid sprites, earlier entry wins
      clear_table();
      set_spr(1, 8'd50, 5'd3, 1'b0, 0);
      set_spr(2, 8'd60, 5'd30, 1'b0, 0);
      set_spr(5, 8'd40, 5'd12, 1'b1, 0);
      run_line("R3", 1'b0);
      // R5: front sprite has holes, rear sprite shows through
      clear_table();
      set_spr(0, 8'd80, 5'd7, 1'b0, 1);
      set_spr(1, 8'd80, 5'd21, 1'b0, 0);
      run_line("R5", 1'b0);
      // R6: only some entries valid
      clear_table();
      set_spr(2, 8'd10, 5'd4, 1'b0, 0);
      set_spr(6, 8'd150, 5'd26, 1'b0, 0);
      t_valid[2] = 1'b0;
      run_line("R6", 1'b0);
      // R7: wrap past the right edge
      clear_table();
      set_spr(4, 8'd240, 5'd11, 1'b0, 0);
      set_spr(7, 8'd250, 5'd29, 1'b1, 0);
      run_line("R7", 1'b0);
      // R8: whole-line mirror
      clear_table();
      set_spr(0, 8'd5, 5'd14, 1'b0, 1);
      set_spr(1, 8'd200, 5'd1, 1'b1, 0);
      flip_scr = 1'b1;
      run_line("R8", 1'b0);
      flip_scr = 1'b0;
      // R4: dense line then an empty line must read back zero
      clear_table();
      for (int e = 0; e < 8; e++) set_spr(e, 8'(e * 32), 5'(e + 2), 1'(e % 2), 0);
      run_line("R4", 1'b0);
      clear_table();
      run_line("R4", 1'b0);
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule